// File: doc/BRIEF.md
# Low-Quadword Vector Move Unit

This execution unit carries out a 64-bit vector load or store between memory and a file of sixteen 256-bit vector registers. Instruction fields arrive already extracted: the operand-size prefix flag, the opcode byte, whether the instruction uses the VEX form, the VEX length bit, the raw (inverted) VEX source field, the ModRM mode and reg fields, and the register-extension bit. The unit checks legality, reads its operands from the register file when it accepts the command, and then performs a single memory transaction over a 64-bit port with valid/ready handshakes.

A load combines the returned 64-bit value with register contents. The merge depends on the form: the legacy form replaces only the lowest quadword. The VEX form also copies the second quadword from a source register and clears the upper half. A store sends the lowest quadword of a register to memory. Encodings that are not allowed raise a one-cycle undefined-opcode pulse with no side effects. Data passes through bit for bit, and the unit never signals a floating-point exception. The register file also has a full-width fill port and a read port for the rest of the datapath.

Top module: `qmove_unit`

## Requirements
- R1: After reset, busy, done, ud_fault, mem_req_valid and mem_rsp_ready are 0, and every register reads as zero.
- R2: A legal legacy load (cmd_vex=0, opcode 8'h12) writes mem_rsp_data into bits 63:0 of the destination and leaves bits 255:64 unchanged. The register changes only at the clock edge where mem_rsp_valid and mem_rsp_ready are both high.
- R3: A legal VEX load writes mem_rsp_data into bits 63:0 and bits 127:64 of the register indexed by ~cmd_vsel_n, with both values taken at acceptance, and writes zero to bits 255:128.
- R4: A legal store (opcode 8'h13) drives mem_req_write=1 with mem_req_wdata equal to bits 63:0 of the selected register at acceptance. It changes no register, and done pulses in the cycle after the request handshake.
- R5: A VEX command with cmd_vex_wide=1 is undefined.
- R6: A VEX store whose cmd_vsel_n is not 4'b1111 is undefined. A VEX load accepts any cmd_vsel_n.
- R7: A command with cmd_rm_mode=2'b11 is undefined, for both load and store.
- R8: A command without cmd_opsize_pfx, or with an opcode other than 8'h12 or 8'h13, is undefined.
- R9: For an undefined command, ud_fault is high for exactly the cycle after acceptance. No memory request is made, no register is written, and busy stays 0.
- R10: The destination or store-source register index is {cmd_reg_hi, cmd_reg_lo}, so registers 8 to 15 are reachable.
- R11: busy is high from the cycle after a legal command is accepted until done pulses. A cmd_valid raised while busy is ignored. done and ud_fault are never high together.
- R12: While mem_req_valid is high and mem_req_ready is low, the request stays asserted with the same mem_req_write and mem_req_wdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present; taken when busy is low |
| cmd_opsize_pfx | input | 1 | Operand-size prefix present (or the VEX equivalent) |
| cmd_opcode | input | 8 | Opcode byte |
| cmd_vex | input | 1 | 1 = VEX form, 0 = legacy form |
| cmd_vex_wide | input | 1 | VEX length bit |
| cmd_vsel_n | input | 4 | Raw inverted VEX source-register field |
| cmd_rm_mode | input | 2 | ModRM mode field |
| cmd_reg_lo | input | 3 | ModRM reg field |
| cmd_reg_hi | input | 1 | Register-extension bit |
| busy | output | 1 | A legal command is in flight |
| done | output | 1 | One-cycle completion pulse |
| ud_fault | output | 1 | One-cycle undefined-opcode pulse |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write (store), 0 = read (load) |
| mem_req_wdata | output | 64 | Store data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |
| mem_rsp_ready | output | 1 | Unit waiting for read data |
| fill_valid | input | 1 | Full-width register write from the datapath |
| fill_idx | input | 4 | Fill register index |
| fill_data | input | 256 | Fill data |
| rd_idx | input | 4 | Read port index |
| rd_data | output | 256 | Read port data (combinational) |

## Verification
The assertions assume the memory side behaves: mem_rsp_valid comes only while mem_rsp_ready is high, and the fill port never targets a register during the edge where a load commits. The bench models memory as a transaction-level task that raises ready or response only at the expected state, after a random wait of one to three cycles. It also keeps fill writes apart from command traffic. Commands come from a seeded $urandom mix of near-legal and deliberately broken encodings, alongside directed corner cases.

// File: rtl/qmove_pkg.sv
package qmove_pkg;
  localparam int QW_D   = 64;
  localparam int VW_D   = 256;
  localparam int NREG_D = 16;
  localparam logic [7:0] OPC_LOAD  = 8'h12;
  localparam logic [7:0] OPC_STORE = 8'h13;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP} qm_state_e;

  // legality of a pre-extracted encoding
  function automatic logic cmd_legal(logic pfx, logic [7:0] op, logic vex,
                                     logic vwide, logic [3:0] vsel_n,
                                     logic [1:0] rm_mode);
    logic known;
    known = pfx && (op == OPC_LOAD || op == OPC_STORE);
    return known && (rm_mode != 2'b11) && !(vex && vwide)
           && !(vex && op == OPC_STORE && vsel_n != 4'b1111);
  endfunction

  // lanes of the destination a load touches
  function automatic logic [VW_D/QW_D-1:0] load_mask(logic vex);
    return vex ? {(VW_D/QW_D){1'b1}} : {{(VW_D/QW_D-1){1'b0}}, 1'b1};
  endfunction

  // full-width image written for a load (lanes outside the mask are ignored)
  function automatic logic [VW_D-1:0] load_data(logic [QW_D-1:0] mem_val,
                                                logic [QW_D-1:0] src_hi);
    return {{(VW_D-2*QW_D){1'b0}}, src_hi, mem_val};
  endfunction
endpackage

// File: rtl/qmove_decode.sv
module qmove_decode
  import qmove_pkg::*;
#(
  parameter int IDXW = 4
) (
  input  logic            pfx,
  input  logic [7:0]      opcode,
  input  logic            vex,
  input  logic            vwide,
  input  logic [3:0]      vsel_n,
  input  logic [1:0]      rm_mode,
  input  logic [2:0]      reg_lo,
  input  logic            reg_hi,
  output logic            legal,
  output logic            is_store,
  output logic [IDXW-1:0] dst_idx,
  output logic [IDXW-1:0] src_idx
);
  always_comb begin
    legal    = cmd_legal(pfx, opcode, vex, vwide, vsel_n, rm_mode);
    is_store = (opcode == OPC_STORE);
    dst_idx  = IDXW'({reg_hi, reg_lo});
    src_idx  = IDXW'(~vsel_n);
  end
endmodule

// File: rtl/qmove_regfile.sv
module qmove_regfile #(
  parameter int NREG = 16,
  parameter int VW   = 256,
  parameter int QW   = 64,
  localparam int LANES = VW / QW,
  localparam int IDXW  = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_we,
  input  logic [IDXW-1:0]  a_idx,
  input  logic [LANES-1:0] a_mask,
  input  logic [VW-1:0]    a_data,
  input  logic             b_we,
  input  logic [IDXW-1:0]  b_idx,
  input  logic [VW-1:0]    b_data,
  input  logic [IDXW-1:0]  lo_idx,
  output logic [QW-1:0]    lo_data,
  input  logic [IDXW-1:0]  hi_idx,
  output logic [QW-1:0]    hi_data,
  input  logic [IDXW-1:0]  rd_idx,
  output logic [VW-1:0]    rd_data
);
  logic [VW-1:0] rows [NREG];

  for (genvar e = 0; e < NREG; e++) begin : g_row
    logic [VW-1:0] row_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_q <= '0;
      end else begin
        for (int l = 0; l < LANES; l++) begin
          if (a_we && a_idx == IDXW'(e) && a_mask[l])
            row_q[l*QW +: QW] <= a_data[l*QW +: QW];
          else if (b_we && b_idx == IDXW'(e))
            row_q[l*QW +: QW] <= b_data[l*QW +: QW];
        end
      end
    end
    assign rows[e] = row_q;
  end

  assign lo_data = rows[lo_idx][QW-1:0];
  assign hi_data = rows[hi_idx][2*QW-1:QW];
  assign rd_data = rows[rd_idx];
endmodule

// File: rtl/qmove_ctrl.sv
module qmove_ctrl
  import qmove_pkg::*;
#(
  parameter int VW   = 256,
  parameter int QW   = 64,
  parameter int IDXW = 4,
  localparam int LANES = VW / QW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             dec_legal,
  input  logic             dec_store,
  input  logic             dec_vex,
  input  logic [IDXW-1:0]  dec_dst,
  input  logic [QW-1:0]    dst_lo,
  input  logic [QW-1:0]    src_hi,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic [QW-1:0]    mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [QW-1:0]    mem_rsp_data,
  output logic             mem_rsp_ready,
  output logic             ld_we,
  output logic [IDXW-1:0]  ld_idx,
  output logic [LANES-1:0] ld_mask,
  output logic [VW-1:0]    ld_data,
  output logic             busy,
  output logic             done,
  output logic             ud_fault,
  output logic             cmd_accept,
  output logic             ud_event
);
  qm_state_e       state_q, state_d;
  logic            store_q, vex_q;
  logic [IDXW-1:0] dst_q;
  logic [QW-1:0]   opnd_q;
  logic            go, req_fire, rsp_fire;

  assign cmd_accept = cmd_valid && (state_q == ST_IDLE);
  assign ud_event   = cmd_accept && !dec_legal;
  assign go         = cmd_accept && dec_legal;
  assign req_fire   = (state_q == ST_REQ) && mem_req_ready;
  assign rsp_fire   = (state_q == ST_RSP) && mem_rsp_valid;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (go) state_d = ST_REQ;
      ST_REQ:  if (req_fire) state_d = store_q ? ST_IDLE : ST_RSP;
      ST_RSP:  if (rsp_fire) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      store_q  <= 1'b0;
      vex_q    <= 1'b0;
      dst_q    <= '0;
      opnd_q   <= '0;
      done     <= 1'b0;
      ud_fault <= 1'b0;
    end else begin
      state_q  <= state_d;
      done     <= (req_fire && store_q) || rsp_fire;
      ud_fault <= ud_event;
      if (go) begin
        store_q <= dec_store;
        vex_q   <= dec_vex;
        dst_q   <= dec_dst;
        opnd_q  <= dec_store ? dst_lo : src_hi;
      end
    end
  end

  assign busy          = (state_q != ST_IDLE);
  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_req_write = store_q;
  assign mem_req_wdata = store_q ? opnd_q : '0;
  assign mem_rsp_ready = (state_q == ST_RSP);
  assign ld_we         = rsp_fire;
  assign ld_idx        = dst_q;
  assign ld_mask       = load_mask(vex_q);
  assign ld_data       = load_data(mem_rsp_data, opnd_q);
endmodule

// File: rtl/qmove_unit.sv
module qmove_unit
  import qmove_pkg::*;
#(
  parameter int NREG = NREG_D,
  parameter int VW   = VW_D,
  parameter int QW   = QW_D,
  localparam int LANES = VW / QW,
  localparam int IDXW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic            cmd_opsize_pfx,
  input  logic [7:0]      cmd_opcode,
  input  logic            cmd_vex,
  input  logic            cmd_vex_wide,
  input  logic [3:0]      cmd_vsel_n,
  input  logic [1:0]      cmd_rm_mode,
  input  logic [2:0]      cmd_reg_lo,
  input  logic            cmd_reg_hi,
  output logic            busy,
  output logic            done,
  output logic            ud_fault,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_write,
  output logic [QW-1:0]   mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [QW-1:0]   mem_rsp_data,
  output logic            mem_rsp_ready,
  input  logic            fill_valid,
  input  logic [IDXW-1:0] fill_idx,
  input  logic [VW-1:0]   fill_data,
  input  logic [IDXW-1:0] rd_idx,
  output logic [VW-1:0]   rd_data
);
  logic             dec_legal, dec_store;
  logic [IDXW-1:0]  dec_dst, dec_src;
  logic [QW-1:0]    dst_lo, src_hi;
  logic             ld_we;
  logic [IDXW-1:0]  ld_idx;
  logic [LANES-1:0] ld_mask;
  logic [VW-1:0]    ld_data;
  logic             cmd_accept, ud_event;

  qmove_decode #(.IDXW(IDXW)) u_dec (
    .pfx(cmd_opsize_pfx), .opcode(cmd_opcode), .vex(cmd_vex),
    .vwide(cmd_vex_wide), .vsel_n(cmd_vsel_n), .rm_mode(cmd_rm_mode),
    .reg_lo(cmd_reg_lo), .reg_hi(cmd_reg_hi), .legal(dec_legal),
    .is_store(dec_store), .dst_idx(dec_dst), .src_idx(dec_src)
  );

  qmove_regfile #(.NREG(NREG), .VW(VW), .QW(QW)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .a_we(ld_we), .a_idx(ld_idx), .a_mask(ld_mask), .a_data(ld_data),
    .b_we(fill_valid), .b_idx(fill_idx), .b_data(fill_data),
    .lo_idx(dec_dst), .lo_data(dst_lo),
    .hi_idx(dec_src), .hi_data(src_hi),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  qmove_ctrl #(.VW(VW), .QW(QW), .IDXW(IDXW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
    .dec_legal(dec_legal), .dec_store(dec_store), .dec_vex(cmd_vex),
    .dec_dst(dec_dst), .dst_lo(dst_lo), .src_hi(src_hi),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mem_rsp_ready(mem_rsp_ready),
    .ld_we(ld_we), .ld_idx(ld_idx), .ld_mask(ld_mask), .ld_data(ld_data),
    .busy(busy), .done(done), .ud_fault(ud_fault),
    .cmd_accept(cmd_accept), .ud_event(ud_event)
  );
endmodule

// File: rtl/qmove_unit_chk.sv
module qmove_unit_chk #(
  parameter int QW = 64,
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             ud_fault,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic             mem_req_write,
  input logic [QW-1:0]    mem_req_wdata,
  input logic             mem_rsp_valid,
  input logic             mem_rsp_ready,
  input logic             cmd_accept,
  input logic             ud_event,
  input logic             ld_we,
  input logic [LANES-1:0] ld_mask
);
  // R9
  ud_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ud_event |=> (ud_fault && !busy && !mem_req_valid));
  // R9
  ud_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ud_fault |-> $past(ud_event));
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_write) && $stable(mem_req_wdata)));
  // R2
  ld_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we |-> (mem_rsp_valid && mem_rsp_ready));
  // R4
  st_no_rf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> !ld_we);
  // R3
  ld_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we |-> ($countones(ld_mask) == 1 || $countones(ld_mask) == LANES));
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req_valid && !mem_rsp_ready));
  // R11
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_accept && !ud_event) |=> busy);
  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && ud_fault));
endmodule

bind qmove_unit qmove_unit_chk #(.QW(QW), .LANES(LANES)) u_chk (.*);

// File: tb/qmove_unit_tb.sv
`timescale 1ns/1ps
module qmove_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 0, cmd_opsize_pfx = 0, cmd_vex = 0, cmd_vex_wide = 0, cmd_reg_hi = 0;
  logic [7:0]   cmd_opcode = '0;
  logic [3:0]   cmd_vsel_n = '0;
  logic [1:0]   cmd_rm_mode = '0;
  logic [2:0]   cmd_reg_lo = '0;
  logic         busy, done, ud_fault, mem_req_valid, mem_req_write, mem_rsp_ready;
  logic         mem_req_ready = 0, mem_rsp_valid = 0;
  logic [63:0]  mem_req_wdata;
  logic [63:0]  mem_rsp_data = '0;
  logic         fill_valid = 0;
  logic [3:0]   fill_idx = '0, rd_idx = '0;
  logic [255:0] fill_data = '0;
  logic [255:0] rd_data;

  logic [255:0] model [16];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  qmove_unit u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                     input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  // bench-side restatement of the encoding rules; returns "" when legal
  function automatic string ud_reason(bit pfx, logic [7:0] op, bit vex, bit wide,
                                      logic [3:0] vsel, logic [1:0] mode);
    if (!pfx || !(op == 8'h12 || op == 8'h13)) return "R8";
    if (mode == 2'b11) return "R7";
    if (vex && wide) return "R5";
    if (vex && op == 8'h13 && vsel != 4'hF) return "R6";
    return "";
  endfunction

  function automatic logic [255:0] exp_load(logic [255:0] old, logic [63:0] mv,
                                            logic [255:0] src, bit vex);
    if (vex) return {128'd0, src[127:64], mv};
    return {old[255:64], mv};
  endfunction

  task automatic peek(input logic [3:0] idx, output logic [255:0] val);
    rd_idx = idx;
    #0.1;
    val = rd_data;
  endtask

  task automatic fill(input logic [3:0] idx, input logic [255:0] val);
    fill_valid = 1; fill_idx = idx; fill_data = val;
    @(negedge clk);
    fill_valid = 0;
    model[idx] = val;
  endtask

  function automatic logic [255:0] rnd256();
    return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic do_cmd(input bit pfx, input logic [7:0] op, input bit vex, input bit wide,
                        input logic [3:0] vsel, input logic [1:0] mode,
                        input logic [2:0] rlo, input bit rhi, input logic [63:0] mv);
    string why;
    logic [3:0] dst, src;
    logic [255:0] v, expv, src_val;
    bit store;
    int k;
    why = ud_reason(pfx, op, vex, wide, vsel, mode);
    dst = {rhi, rlo};
    src = ~vsel;
    store = (op == 8'h13);
    src_val = model[src];
    cmd_opsize_pfx = pfx; cmd_opcode = op; cmd_vex = vex; cmd_vex_wide = wide;
    cmd_vsel_n = vsel; cmd_rm_mode = mode; cmd_reg_lo = rlo; cmd_reg_hi = rhi;
    cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    if (why != "") begin
      chk(ud_fault == 1'b1, {why, " ud_fault raised"}, 256'(ud_fault), 256'd1);
      chk(!busy && !mem_req_valid, "R9 no request on fault",
          256'({busy, mem_req_valid}), 256'd0);
      @(negedge clk);
      chk(ud_fault == 1'b0 && !mem_req_valid, "R9 single-cycle fault", 256'(ud_fault), 256'd0);
      peek(dst, v);
      chk(v == model[dst], "R9 register untouched", v, model[dst]);
      return;
    end
    chk(busy && mem_req_valid && !ud_fault, "R11 busy and request after accept",
        256'({busy, mem_req_valid, ud_fault}), 256'b110);
    chk(mem_req_write == store, "R4 request direction", 256'(mem_req_write), 256'(store));
    if (store)
      chk(mem_req_wdata == model[dst][63:0], "R4 R10 store data",
          256'(mem_req_wdata), 256'(model[dst][63:0]));
    // a command offered while busy must be ignored
    cmd_valid = 1; cmd_opsize_pfx = 1; cmd_opcode = 8'h13; cmd_vex = 0; cmd_rm_mode = 2'b00;
    k = 1 + ($urandom % 3);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      cmd_valid = 0;
      chk(mem_req_valid && mem_req_write == store && !done, "R12 request held",
          256'({mem_req_valid, mem_req_write}), 256'({1'b1, store}));
    end
    mem_req_ready = 1;
    @(negedge clk);
    mem_req_ready = 0;
    if (store) begin
      chk(done && !busy, "R4 done after write handshake", 256'({done, busy}), 256'b10);
      peek(dst, v);
      chk(v == model[dst], "R4 store leaves register", v, model[dst]);
    end else begin
      chk(!done && busy && mem_rsp_ready && !mem_req_valid, "R2 waiting for response",
          256'({done, busy, mem_rsp_ready, mem_req_valid}), 256'b0110);
      k = $urandom % 3;
      for (int i = 0; i < k; i++) @(negedge clk);
      peek(dst, v);
      chk(v == model[dst], "R2 no write before response", v, model[dst]);
      mem_rsp_valid = 1; mem_rsp_data = mv;
      @(negedge clk);
      mem_rsp_valid = 0;
      expv = exp_load(model[dst], mv, src_val, vex);
      model[dst] = expv;
      peek(dst, v);
      chk(v == expv, vex ? "R3 VEX load merge" : "R2 legacy load merge", v, expv);
      chk(done && !busy, "R11 done after response", 256'({done, busy}), 256'b10);
    end
    @(negedge clk);
    chk(!done && !mem_req_valid && !busy, "R11 ignored command made no request",
        256'({done, mem_req_valid, busy}), 256'd0);
  endtask

  initial begin
    logic [255:0] v;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && !ud_fault && !mem_req_valid && !mem_rsp_ready, "R1 outputs in reset",
        256'({busy, done, ud_fault, mem_req_valid, mem_rsp_ready}), 256'd0);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      peek(4'(i), v);
      chk(v == '0, "R1 register cleared", v, '0);
    end
    for (int i = 0; i < 16; i++) fill(4'(i), rnd256());

    // directed corner cases
    do_cmd(1, 8'h12, 0, 0, 4'hF, 2'b00, 3'd2, 0, 64'hDEAD_BEEF_0123_4567); // R2
    do_cmd(1, 8'h12, 1, 0, 4'h3, 2'b01, 3'd5, 1, 64'h1111_2222_3333_4444); // R3 R10 src=12 dst=13
    do_cmd(1, 8'h12, 1, 0, 4'h9, 2'b10, 3'd6, 0, 64'hA5A5_A5A5_5A5A_5A5A); // R3 dst==src=6
    do_cmd(1, 8'h13, 0, 0, 4'h0, 2'b00, 3'd7, 1, 64'h0);                   // R4 R10 reg 15
    do_cmd(1, 8'h13, 1, 0, 4'hF, 2'b10, 3'd1, 0, 64'h0);                   // R4 VEX store
    do_cmd(1, 8'h13, 1, 0, 4'hE, 2'b00, 3'd1, 0, 64'h0);                   // R6
    do_cmd(1, 8'h12, 1, 1, 4'hF, 2'b00, 3'd1, 0, 64'h0);                   // R5 load
    do_cmd(1, 8'h13, 1, 1, 4'hF, 2'b00, 3'd1, 0, 64'h0);                   // R5 store
    do_cmd(1, 8'h12, 0, 0, 4'hF, 2'b11, 3'd0, 0, 64'h0);                   // R7 load
    do_cmd(1, 8'h13, 0, 0, 4'hF, 2'b11, 3'd0, 0, 64'h0);                   // R7 store
    do_cmd(1, 8'h14, 0, 0, 4'hF, 2'b00, 3'd0, 0, 64'h0);                   // R8 opcode
    do_cmd(0, 8'h12, 0, 0, 4'hF, 2'b00, 3'd0, 0, 64'h0);                   // R8 prefix
    do_cmd(1, 8'h12, 0, 0, 4'hF, 2'b00, 3'd0, 1, 64'hFFFF_FFFF_FFFF_FFFF); // R2 R10 reg 8

    // seeded random mix
    for (int n = 0; n < 300; n++) begin
      bit pfx, vex, wide;
      logic [7:0] op;
      logic [3:0] vsel;
      if (n % 20 == 0) fill(4'($urandom), rnd256());
      pfx  = ($urandom % 8) != 0;
      op   = ($urandom % 8 == 0) ? 8'($urandom) : (($urandom % 2) ? 8'h12 : 8'h13);
      vex  = $urandom % 2;
      wide = ($urandom % 6) == 0;
      vsel = (op == 8'h13 && ($urandom % 4) != 0) ? 4'hF : 4'($urandom);
      do_cmd(pfx, op, vex, wide, vsel, 2'($urandom), 3'($urandom), 1'($urandom),
             {$urandom, $urandom});
    end
    finish_run();
  end
endmodule